// File: doc/BRIEF.md
# Byte/Word Load-Store Unit

This unit sits between a 32-bit integer datapath and a data memory organised in words. Each cycle it can accept one memory operation. The operation is given as an opcode, a base register value, a signed 16-bit displacement and store data. The unit adds the base and the displacement to form the effective byte address. It then drives a word-wide memory port: a word index, per-byte write enables and lane-formatted write data.

Loads return one cycle after the request, because the memory port has one cycle of read latency. A byte load returns the selected byte sign-extended to 32 bits. A word load returns the whole word.

A configuration input picks how byte addresses inside a word map onto the physical lanes, either little-endian or big-endian. Word data always occupies the lanes in the same physical layout. A word access to an address that is not a multiple of four is refused and raises a flag. An opcode outside the four supported ones does nothing.

Top module: `byte_lsu`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32; `mem_waddr` carries bits [31:2] of it.
- R2: Opcode 0x20 (byte load) raises `ld_valid` in the cycle after acceptance, with `ld_data` equal to the addressed byte sign-extended from its bit 7.
- R3: Opcode 0x23 (word load) raises `ld_valid` in the cycle after acceptance, with `ld_data` equal to the memory word at the word index.
- R4: Opcode 0x28 (byte store) asserts `mem_wr` with exactly one enable bit set, the one for the selected lane. Bits [7:0] of the store data are copied onto all four lanes of `mem_wdata`, and the other bytes of the word keep their values.
- R5: Opcode 0x2b (store word) asserts `mem_wr` with all four enables set, and `mem_wdata` equals the store data unchanged.
- R6: Lane k carries bits [8k+7:8k] of the memory word. With `big_endian` low, the lane is address bits [1:0]. With `big_endian` high, the lane is 3 minus address bits [1:0]. So in little-endian mode a byte stored at address 2 appears in bits [23:16] of a word load, and in big-endian mode in bits [15:8].
- R7: A word load or word store whose address bits [1:0] are not zero raises `misalign` in the same cycle. It issues no `mem_req` and no write, and produces no `ld_valid`.
- R8: Any other opcode issues no `mem_req`, raises no `misalign` and produces no `ld_valid`.
- R9: While reset is held and after it is released, `ld_valid` and `mem_req` are low until a legal request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 selects the big-endian lane mapping |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Memory opcode |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data |
| mem_req | output | 1 | Memory access this cycle |
| mem_wr | output | 1 | Access is a write |
| mem_be | output | 4 | Per-lane write enables |
| mem_waddr | output | 30 | Word index |
| mem_wdata | output | 32 | Lane-formatted write data |
| mem_rdata | input | 32 | Read word, valid one cycle after a read |
| misalign | output | 1 | Misaligned word access refused |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
The bench stores bytes at every lane in both lane mappings, then reads them back as words. A design with a reversed or missing endian swap would return the bytes in the wrong positions. Byte loads of 0x80 and 0x7F cover sign extension: a design that zero-extends, or that extends from the wrong bit, fails on one of the two. A negative displacement that lowers the base checks that the address adder sign-extends; a design that zero-extends the displacement would address a word far above the base. A misaligned word store is followed by a word load of the same word, and an illegal opcode is followed by an idle cycle. A design that leaks a write, or that produces a stray load result, is caught there by the scoreboard.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   localparam int OPC_W = 6;
   localparam logic [OPC_W-1:0] OP_LOAD_BYTE  = 6'h20;
   localparam logic [OPC_W-1:0] OP_LOAD_WORD  = 6'h23;
   localparam logic [OPC_W-1:0] OP_STORE_BYTE = 6'h28;
   localparam logic [OPC_W-1:0] OP_STORE_WORD = 6'h2b;

   typedef struct packed {
      logic is_load;
      logic is_store;
      logic is_byte;
      logic is_word;
   } op_kind_t;

   function automatic op_kind_t decode_op(input logic [OPC_W-1:0] op);
      op_kind_t k;
      k = '0;
      case (op)
         OP_LOAD_BYTE:  begin k.is_load  = 1'b1; k.is_byte = 1'b1; end
         OP_LOAD_WORD:  begin k.is_load  = 1'b1; k.is_word = 1'b1; end
         OP_STORE_BYTE: begin k.is_store = 1'b1; k.is_byte = 1'b1; end
         OP_STORE_WORD: begin k.is_store = 1'b1; k.is_word = 1'b1; end
         default:       k = '0;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] eff_addr
);
   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("lsu_agen: OFF_W must not exceed ADDR_W");
   end

   logic [ADDR_W-1:0] off_ext;

   if (OFF_W == ADDR_W) begin : g_no_ext
      assign off_ext = offset;
   end else begin : g_sext
      assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
   end

   assign eff_addr = base + off_ext;
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LSB_W = $clog2(LANES)
) (
   input  logic              is_byte,
   input  logic              is_word,
   input  logic [LSB_W-1:0]  lane,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata_out
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i] = is_word | (is_byte & (lane == LSB_W'(i)));
      assign wdata_out[8*i +: 8] = is_byte ? wdata_in[7:0] : wdata_in[8*i +: 8];
   end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt #(
   parameter int DATA_W = 32,
   parameter bit SIGN_EXT = 1'b1,
   localparam int LANES = DATA_W / 8,
   localparam int LSB_W = $clog2(LANES)
) (
   input  logic              is_byte,
   input  logic [LSB_W-1:0]  lane,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data_out
);
   logic [7:0]        sel_byte;
   logic [DATA_W-1:0] byte_ext;

   always_comb begin
      sel_byte = 8'h00;
      for (int i = 0; i < LANES; i++) begin
         if (lane == LSB_W'(i)) sel_byte = rdata[8*i +: 8];
      end
   end

   if (SIGN_EXT) begin : g_sext
      assign byte_ext = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
   end else begin : g_zext
      assign byte_ext = {{(DATA_W-8){1'b0}}, sel_byte};
   end

   assign data_out = is_byte ? byte_ext : rdata;
endmodule

// File: rtl/byte_lsu.sv
module byte_lsu #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   localparam int LANES = DATA_W / 8,
   localparam int LSB_W = $clog2(LANES),
   localparam int OPC_W = lsu_pkg::OPC_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    big_endian,
   input  logic                    req_valid,
   input  logic [OPC_W-1:0]        req_op,
   input  logic [ADDR_W-1:0]       req_base,
   input  logic [OFF_W-1:0]        req_offset,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic                    mem_req,
   output logic                    mem_wr,
   output logic [LANES-1:0]        mem_be,
   output logic [ADDR_W-LSB_W-1:0] mem_waddr,
   output logic [DATA_W-1:0]       mem_wdata,
   input  logic [DATA_W-1:0]       mem_rdata,
   output logic                    misalign,
   output logic                    ld_valid,
   output logic [DATA_W-1:0]       ld_data
);
   import lsu_pkg::*;

   if (DATA_W % 8 != 0 || LANES < 2 || (1 << LSB_W) != LANES) begin : g_bad_width
      $error("byte_lsu: DATA_W must be a power-of-two multiple of 8, at least 16");
   end
   if (ADDR_W <= LSB_W) begin : g_bad_addr
      $error("byte_lsu: ADDR_W too small");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic [LSB_W-1:0]  byte_off;
   logic [LSB_W-1:0]  lane;
   op_kind_t          kind;
   logic              word_misal;
   logic              accept;
   logic              pend_valid;
   logic              pend_byte;
   logic [LSB_W-1:0]  pend_lane;

   lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
      .base     (req_base),
      .offset   (req_offset),
      .eff_addr (eff_addr)
   );

   assign kind       = req_valid ? decode_op(req_op) : '0;
   assign byte_off   = eff_addr[LSB_W-1:0];
   assign lane       = big_endian ? (LSB_W'(LANES-1) - byte_off) : byte_off;
   assign word_misal = kind.is_word & (byte_off != '0);
   assign accept     = (kind.is_load | kind.is_store) & ~word_misal;

   assign mem_req   = accept;
   assign mem_wr    = accept & kind.is_store;
   assign mem_waddr = eff_addr[ADDR_W-1:LSB_W];
   assign misalign  = word_misal;

   logic [LANES-1:0] be_raw;

   lsu_store_fmt #(.DATA_W(DATA_W)) u_store_fmt (
      .is_byte   (kind.is_byte),
      .is_word   (kind.is_word),
      .lane      (lane),
      .wdata_in  (req_wdata),
      .be        (be_raw),
      .wdata_out (mem_wdata)
   );

   assign mem_be = mem_wr ? be_raw : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_byte  <= 1'b0;
         pend_lane  <= '0;
      end else begin
         pend_valid <= accept & kind.is_load;
         pend_byte  <= kind.is_byte;
         pend_lane  <= lane;
      end
   end

   lsu_load_fmt #(.DATA_W(DATA_W), .SIGN_EXT(1'b1)) u_load_fmt (
      .is_byte  (pend_byte),
      .lane     (pend_lane),
      .rdata    (mem_rdata),
      .data_out (ld_data)
   );

   assign ld_valid = pend_valid;

   AST_LB_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && pend_byte) |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}})) // R2
      else $error("byte load result not sign-extended");
   AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(mem_req && !mem_wr)) // R3
      else $error("load result without a preceding read");
   AST_SB_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && req_op == OP_STORE_BYTE) |-> $onehot(mem_be)) // R4
      else $error("byte store enables not one-hot");
   AST_MISAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_req && mem_be == '0) ##1 !ld_valid) // R7
      else $error("misaligned access reached memory");
   AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_op != OP_LOAD_BYTE && req_op != OP_LOAD_WORD &&
       req_op != OP_STORE_BYTE && req_op != OP_STORE_WORD) |-> (!mem_req && !misalign)) // R8
      else $error("unsupported opcode caused activity");
endmodule

// File: tb/byte_lsu_bench.sv
module byte_lsu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_op = 6'h00;
   logic [31:0] req_base = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req, mem_wr, misalign, ld_valid;
   logic [3:0]  mem_be;
   logic [29:0] mem_waddr;
   logic [31:0] mem_wdata, mem_rdata, ld_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] ram [0:255];
   logic [7:0]  gold [0:1023];

   always #5 clk = ~clk;

   byte_lsu u_byte_lsu (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
      .req_op(req_op), .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
      .mem_req(mem_req), .mem_wr(mem_wr), .mem_be(mem_be), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign(misalign),
      .ld_valid(ld_valid), .ld_data(ld_data)
   );

   initial begin
      for (int i = 0; i < 256; i++) ram[i] = '0;
      for (int i = 0; i < 1024; i++) gold[i] = '0;
      mem_rdata = '0;
   end

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_wr) begin
            for (int l = 0; l < 4; l++)
               if (mem_be[l]) ram[mem_waddr[7:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
         end else begin
            mem_rdata <= ram[mem_waddr[7:0]];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && ld_valid) begin
         if (exp_q.size() == 0) chk("R8 stray ld_valid", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), ld_data, exp_q.pop_front());
      end
   end

   function automatic logic [1:0] lane_of(input logic [31:0] a);
      return big_endian ? 2'd3 - a[1:0] : a[1:0];
   endfunction

   function automatic logic [31:0] gold_word(input logic [31:0] a);
      if (big_endian) return {gold[a], gold[a+1], gold[a+2], gold[a+3]};
      return {gold[a+3], gold[a+2], gold[a+1], gold[a]};
   endfunction

   task automatic issue(input logic [5:0] op, input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] wd, input string tag);
      logic [31:0] ea;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
      ea = base + {{16{off[15]}}, off};
      #1;
      case (op)
         6'h20: begin
            exp_q.push_back({{24{gold[ea][7]}}, gold[ea]}); tag_q.push_back({tag, " R2 byte load"});
         end
         6'h23: begin
            if (ea[1:0] == 2'b00) begin
               exp_q.push_back(gold_word(ea)); tag_q.push_back({tag, " R3 word load"});
            end
         end
         6'h28: begin
            chk({tag, " R4 be one lane (R6 mapping)"}, {28'd0, mem_be}, 32'(4'b1 << lane_of(ea)));
            chk({tag, " R4 byte replicated"}, mem_wdata, {4{wd[7:0]}});
            gold[ea] = wd[7:0];
         end
         6'h2b: begin
            if (ea[1:0] == 2'b00) begin
               chk({tag, " R5 be all"}, {28'd0, mem_be}, 32'hF);
               chk({tag, " R5 wdata"}, mem_wdata, wd);
               if (big_endian) {gold[ea], gold[ea+1], gold[ea+2], gold[ea+3]} = wd;
               else {gold[ea+3], gold[ea+2], gold[ea+1], gold[ea]} = wd;
            end
         end
         default: ;
      endcase
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_op = 6'h00;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 ld_valid in reset", {31'd0, ld_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ld_valid after reset", {31'd0, ld_valid}, 32'd0);
      chk("R9 mem_req after reset", {31'd0, mem_req}, 32'd0);

      // little-endian region 0x000
      big_endian = 1'b0;
      issue(6'h2b, 32'h0, 16'h0, 32'h11223344, "le sw");
      issue(6'h28, 32'h0, 16'h2, 32'hABCDEF80, "le sb addr2");
      chk("R1 waddr", {2'b0, mem_waddr}, 32'd0);
      issue(6'h23, 32'h0, 16'h0, '0, "le R6 lw");
      issue(6'h20, 32'h0, 16'h2, '0, "le lb 0x80");
      issue(6'h28, 32'h8, 16'h1, 32'h7F, "le sb addr9");
      issue(6'h20, 32'h9, 16'h0, '0, "le lb 0x7f");
      issue(6'h28, 32'h10, 16'h0, 32'hA1, "le sb lane0");
      issue(6'h28, 32'h10, 16'h3, 32'hB4, "le sb lane3");
      issue(6'h23, 32'h10, 16'h0, '0, "le lw lanes");

      // negative offset
      issue(6'h2b, 32'h44, 16'hFFF8, 32'hCAFEF00D, "R1 neg off sw");
      chk("R1 neg offset waddr", {2'b0, mem_waddr}, 32'h0F);
      issue(6'h23, 32'h3C, 16'h0, '0, "R1 readback");

      // misaligned word store, then readback
      issue(6'h2b, 32'h0, 16'h1, 32'hDEADBEEF, "R7 mis sw");
      chk("R7 misalign flag", {31'd0, misalign}, 32'd1);
      chk("R7 no mem_req", {31'd0, mem_req}, 32'd0);
      chk("R7 no enables", {28'd0, mem_be}, 32'd0);
      issue(6'h23, 32'h0, 16'h3, '0, "R7 mis lw");
      chk("R7 misalign lw", {31'd0, misalign}, 32'd1);
      issue(6'h23, 32'h0, 16'h0, '0, "R7 unchanged");

      // illegal opcode
      issue(6'h24, 32'h0, 16'h0, 32'hFFFFFFFF, "R8 bad op");
      chk("R8 no mem_req", {31'd0, mem_req}, 32'd0);
      chk("R8 no misalign", {31'd0, misalign}, 32'd0);
      issue(6'h2a, 32'h0, 16'h1, 32'hFFFFFFFF, "R8 bad op2");
      chk("R8 no mem_req 2", {31'd0, mem_req}, 32'd0);
      idle();

      // big-endian region 0x200
      big_endian = 1'b1;
      issue(6'h2b, 32'h200, 16'h0, 32'h0, "be sw clr");
      issue(6'h28, 32'h200, 16'h2, 32'h5A, "be sb addr2");
      issue(6'h23, 32'h200, 16'h0, '0, "be R6 lw");
      issue(6'h28, 32'h204, 16'h0, 32'h81, "be sb lane3");
      issue(6'h28, 32'h204, 16'h3, 32'h42, "be sb lane0");
      issue(6'h23, 32'h204, 16'h0, '0, "be lw lanes");
      issue(6'h20, 32'h204, 16'h0, '0, "be lb 0x81");
      issue(6'h2b, 32'h208, 16'h0, 32'h01020304, "be sw");
      issue(6'h20, 32'h208, 16'h0, '0, "be lb msb");
      issue(6'h20, 32'h208, 16'h3, '0, "be lb lsb");
      idle();
      repeat (3) @(negedge clk);
      chk("scoreboard drained", exp_q.size(), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule